// File: doc/BRIEF.md
# Shared Bus Arbiter with Alternating Favoured Turns

This block decides which requester owns a shared parallel bus. There is one host requester and a parameterised number of device slots, four by default. Each requester has its own request line and grant line, and exactly one grant line is high at any time. The arbiter makes a new decision only in a cycle where `arb_point` is high, which marks a bus idle cycle or the boundary between two transactions. In every other cycle the grant stays where it is.

Decisions alternate between a favoured turn and a normal turn. The host can be marked as favoured, and any subset of the slots can be marked as favoured. On a favoured turn a favoured requester that is asking wins. On a normal turn all eligible requesters share the bus in round-robin order. A per-slot enable mask hides slots from arbitration entirely. When nothing eligible is requesting, the bus is parked. One parking setting parks it on the host; the other leaves it with the requester that held it last.

Top module: `bus_arbiter`

## Requirements
- R1: After reset, `host_gnt` is 1 and every bit of `slot_gnt` is 0.
- R2: In a cycle where `arb_point` is low, the grant outputs in the next cycle equal their present values, whatever the request inputs do.
- R3: Requester indices are 0 for the host and i+1 for slot bit i. With no favoured requester asking, successive decisions serve the eligible requesters round-robin, starting from the index after the one last granted by round-robin. The round-robin pointer starts at the host (0) after reset.
- R4: A slot whose `slot_en` bit is 0 is never granted by a decision. If only disabled slots are requesting, the bus is parked as in R8 or R9. The host is always eligible.
- R5: When `host_fav` is 1 and the host is requesting, every favoured turn grants the host. Turns alternate, and the first decision after reset is a favoured turn, so the host gets every other grant while other requesters take the normal turns in round-robin order.
- R6: On a favoured turn when the host does not win, an eligible requesting slot whose `slot_fav` bit is 1 is granted. Several such slots are served round-robin among themselves.
- R7: A favoured turn on which no favoured requester is asking falls back to normal round-robin, and the turn is still used up.
- R8: With `park_prev` at 0, a decision with no eligible request moves the grant to the host.
- R9: With `park_prev` at 1, a decision with no eligible request leaves the grant with its current holder. This is the host after reset.
- R10: A decision with no eligible request does not advance the favoured/normal alternation.
- R11: Exactly one grant output is high in every cycle after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arb_point | input | 1 | High in a cycle where a new grant decision is taken |
| host_req | input | 1 | Host bus request |
| slot_req | input | N_SLOTS | Slot bus requests, bit i is requester i+1 |
| slot_en | input | N_SLOTS | Per-slot arbitration enable |
| host_fav | input | 1 | Host is favoured on alternate decisions |
| slot_fav | input | N_SLOTS | Slots favoured on alternate decisions |
| park_prev | input | 1 | 0: idle bus parks on host; 1: idle bus stays with last holder |
| host_gnt | output | 1 | Host bus grant |
| slot_gnt | output | N_SLOTS | Slot bus grants |

## Verification
The bench drives several request patterns with every requester asking, under three settings: no favour, a favoured host and a single favoured slot. The resulting grant orders tell plain round-robin apart from the two interleaved orders. A pattern where the favoured requesters are silent shows the fallback to round-robin. A masked pattern with only disabled slots asking separates enable gating from parking. Runs of idle decisions under both parking settings, followed by a favoured request, show where the idle bus parks and that idle decisions leave the turn alternation alone.

// File: rtl/bus_arbiter_pkg.sv
package bus_arbiter_pkg;
    typedef enum logic {
        TURN_NORMAL    = 1'b0,
        TURN_FAVOURED  = 1'b1
    } turn_e;
endpackage

// File: rtl/arb_req_gate.sv
module arb_req_gate #(
    parameter int N_SLOTS = 4,
    localparam int NREQ   = N_SLOTS + 1
) (
    input  logic               host_req,
    input  logic [N_SLOTS-1:0] slot_req,
    input  logic [N_SLOTS-1:0] slot_en,
    input  logic [N_SLOTS-1:0] slot_fav,
    output logic [NREQ-1:0]    elig,
    output logic [NREQ-1:0]    fav_slot_elig,
    output logic               any_elig
);
    // index 0 is the host; it has no enable bit and is never in the slot favour set
    assign elig[0]          = host_req;
    assign fav_slot_elig[0] = 1'b0;

    for (genvar i = 0; i < N_SLOTS; i++) begin : g_slot
        assign elig[i+1]          = slot_req[i] & slot_en[i];
        assign fav_slot_elig[i+1] = slot_req[i] & slot_en[i] & slot_fav[i];
    end

    assign any_elig = |elig;
endmodule

// File: rtl/arb_rr_pick.sv
module arb_rr_pick #(
    parameter int W  = 5,
    localparam int IW = (W > 1) ? $clog2(W) : 1
) (
    input  logic [W-1:0]  req,
    input  logic [IW-1:0] ptr,
    output logic          found,
    output logic [IW-1:0] idx
);
    // search order: ptr+1, ptr+2, ... wrapping, ptr itself last
    always_comb begin
        logic [IW:0] pos;
        found = 1'b0;
        idx   = '0;
        for (int k = 1; k <= W; k++) begin
            pos = {1'b0, ptr} + (IW+1)'(k);
            if (pos >= (IW+1)'(W)) begin
                pos = pos - (IW+1)'(W);
            end
            if (!found && req[pos[IW-1:0]]) begin
                found = 1'b1;
                idx   = pos[IW-1:0];
            end
        end
    end
endmodule

// File: rtl/bus_arbiter.sv
module bus_arbiter
    import bus_arbiter_pkg::*;
#(
    parameter int N_SLOTS = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               arb_point,
    input  logic               host_req,
    input  logic [N_SLOTS-1:0] slot_req,
    input  logic [N_SLOTS-1:0] slot_en,
    input  logic               host_fav,
    input  logic [N_SLOTS-1:0] slot_fav,
    input  logic               park_prev,
    output logic               host_gnt,
    output logic [N_SLOTS-1:0] slot_gnt
);
    localparam int NREQ     = N_SLOTS + 1;
    localparam int IW       = $clog2(NREQ);
    localparam logic [IW-1:0] HOST_IDX = '0;

    typedef struct packed {
        logic [NREQ-1:0] gnt;
        logic [IW-1:0]   owner;
        logic [IW-1:0]   norm_ptr;
        logic [IW-1:0]   fav_ptr;
        turn_e           turn;
    } arb_state_t;

    arb_state_t st_d, st_q;

    logic [NREQ-1:0] elig;
    logic [NREQ-1:0] fav_slot_elig;
    logic            any_elig;
    logic            rr_found,  fav_found;
    logic [IW-1:0]   rr_idx,    fav_idx;

    arb_req_gate #(.N_SLOTS(N_SLOTS)) u_gate (
        .host_req      (host_req),
        .slot_req      (slot_req),
        .slot_en       (slot_en),
        .slot_fav      (slot_fav),
        .elig          (elig),
        .fav_slot_elig (fav_slot_elig),
        .any_elig      (any_elig)
    );

    arb_rr_pick #(.W(NREQ)) u_rr_normal (
        .req   (elig),
        .ptr   (st_q.norm_ptr),
        .found (rr_found),
        .idx   (rr_idx)
    );

    arb_rr_pick #(.W(NREQ)) u_rr_fav (
        .req   (fav_slot_elig),
        .ptr   (st_q.fav_ptr),
        .found (fav_found),
        .idx   (fav_idx)
    );

    always_comb begin
        logic [IW-1:0] winner;
        st_d   = st_q;
        winner = st_q.owner;
        if (arb_point) begin
            if (!any_elig) begin
                // idle bus: park, turn alternation untouched
                winner = park_prev ? st_q.owner : HOST_IDX;
            end else begin
                if (st_q.turn == TURN_FAVOURED && host_fav && host_req) begin
                    winner = HOST_IDX;
                end else if (st_q.turn == TURN_FAVOURED && fav_found) begin
                    winner       = fav_idx;
                    st_d.fav_ptr = fav_idx;
                end else if (rr_found) begin
                    winner        = rr_idx;
                    st_d.norm_ptr = rr_idx;
                end
                st_d.turn = (st_q.turn == TURN_FAVOURED) ? TURN_NORMAL : TURN_FAVOURED;
            end
            st_d.owner = winner;
            st_d.gnt   = NREQ'(1) << winner;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.gnt      <= NREQ'(1);
            st_q.owner    <= HOST_IDX;
            st_q.norm_ptr <= HOST_IDX;
            st_q.fav_ptr  <= HOST_IDX;
            st_q.turn     <= TURN_FAVOURED;
        end else begin
            st_q <= st_d;
        end
    end

    assign host_gnt = st_q.gnt[0];
    assign slot_gnt = st_q.gnt[NREQ-1:1];
endmodule

// File: rtl/bus_arbiter_chk.sv
module bus_arbiter_chk #(
    parameter int N_SLOTS = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               arb_point,
    input logic               host_req,
    input logic [N_SLOTS-1:0] slot_req,
    input logic [N_SLOTS-1:0] slot_en,
    input logic               park_prev,
    input logic               host_gnt,
    input logic [N_SLOTS-1:0] slot_gnt
);
    logic any_elig_c;
    assign any_elig_c = host_req | (|(slot_req & slot_en));

    AST_GNT_ONE_HOT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({slot_gnt, host_gnt}) == 1); // R11

    AST_GNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !arb_point |=> $stable({slot_gnt, host_gnt})); // R2

    AST_PARK_ON_HOST: assert property (@(posedge clk) disable iff (!rst_n)
        arb_point && !park_prev && !any_elig_c |=> host_gnt); // R8

    AST_PARK_ON_PREV: assert property (@(posedge clk) disable iff (!rst_n)
        arb_point && park_prev && !any_elig_c |=> $stable({slot_gnt, host_gnt})); // R9

    for (genvar i = 0; i < N_SLOTS; i++) begin : g_en
        AST_DISABLED_NO_GNT: assert property (@(posedge clk) disable iff (!rst_n)
            arb_point && any_elig_c && !slot_en[i] |=> !slot_gnt[i]); // R4
    end
endmodule

bind bus_arbiter bus_arbiter_chk #(.N_SLOTS(N_SLOTS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .arb_point (arb_point),
    .host_req  (host_req),
    .slot_req  (slot_req),
    .slot_en   (slot_en),
    .park_prev (park_prev),
    .host_gnt  (host_gnt),
    .slot_gnt  (slot_gnt)
);

// File: tb/bus_arbiter_bench.sv
`timescale 1ns/1ps
module bus_arbiter_bench;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       arb_point;
    logic       host_req;
    logic [3:0] slot_req;
    logic [3:0] slot_en;
    logic       host_fav;
    logic [3:0] slot_fav;
    logic       park_prev;
    logic       host_gnt;
    logic [3:0] slot_gnt;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    bus_arbiter #(.N_SLOTS(4)) u_bus_arbiter (
        .clk       (clk),
        .rst_n     (rst_n),
        .arb_point (arb_point),
        .host_req  (host_req),
        .slot_req  (slot_req),
        .slot_en   (slot_en),
        .host_fav  (host_fav),
        .slot_fav  (slot_fav),
        .park_prev (park_prev),
        .host_gnt  (host_gnt),
        .slot_gnt  (slot_gnt)
    );

    // grant vector: bit 0 host, bit i+1 slot i
    function automatic logic [4:0] gvec();
        return {slot_gnt, host_gnt};
    endfunction

    task automatic check(input logic [4:0] act, input logic [4:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: grant actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n     = 1'b0;
        arb_point = 1'b0;
        host_req  = 1'b0;
        slot_req  = 4'b0000;
        slot_en   = 4'b1111;
        host_fav  = 1'b0;
        slot_fav  = 4'b0000;
        park_prev = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // one decision cycle; called and returns at a falling edge
    task automatic step(input logic [4:0] exp, input string req);
        arb_point = 1'b1;
        @(negedge clk);
        arb_point = 1'b0;
        check(gvec(), exp, req);
        checks++;
        if ($countones(gvec()) != 1) begin
            fails++;
            $display("FAIL R11: grant actual %b expected one-hot", gvec());
        end
    endtask

    task automatic t_reset();
        do_reset();
        check(gvec(), 5'b00001, "R1");
    endtask

    task automatic t_hold();
        do_reset();
        slot_req = 4'b1111;
        repeat (3) @(negedge clk);
        check(gvec(), 5'b00001, "R2");
        step(5'b00010, "R2");
        slot_req = 4'b0100;
        host_req = 1'b1;
        repeat (2) @(negedge clk);
        check(gvec(), 5'b00010, "R2");
    endtask

    task automatic t_round_robin();
        do_reset();
        host_req = 1'b1;
        slot_req = 4'b1111;
        step(5'b00010, "R3");
        step(5'b00100, "R3");
        step(5'b01000, "R3");
        step(5'b10000, "R3");
        step(5'b00001, "R3");
        step(5'b00010, "R3");
    endtask

    task automatic t_enable();
        do_reset();
        slot_en  = 4'b0101;
        slot_req = 4'b1111;
        step(5'b00010, "R4");
        step(5'b01000, "R4");
        step(5'b00010, "R4");
        slot_req = 4'b1000;
        step(5'b00001, "R4");
    endtask

    task automatic t_host_fav();
        do_reset();
        host_fav = 1'b1;
        host_req = 1'b1;
        slot_req = 4'b1111;
        step(5'b00001, "R5");
        step(5'b00010, "R5");
        step(5'b00001, "R5");
        step(5'b00100, "R5");
        step(5'b00001, "R5");
        step(5'b01000, "R5");
    endtask

    task automatic t_slot_fav();
        do_reset();
        slot_fav = 4'b0100;
        slot_req = 4'b1111;
        step(5'b01000, "R6");
        step(5'b00010, "R6");
        step(5'b01000, "R6");
        step(5'b00100, "R6");
        step(5'b01000, "R6");
        step(5'b01000, "R6");
    endtask

    task automatic t_fallback();
        do_reset();
        host_fav = 1'b1;
        slot_fav = 4'b0100;
        slot_req = 4'b0011;
        step(5'b00010, "R7");
        step(5'b00100, "R7");
        step(5'b00010, "R7");
    endtask

    task automatic t_park_host();
        do_reset();
        slot_req = 4'b0010;
        step(5'b00100, "R8");
        slot_req = 4'b0000;
        step(5'b00001, "R8");
    endtask

    task automatic t_park_prev();
        do_reset();
        park_prev = 1'b1;
        step(5'b00001, "R9");
        slot_req = 4'b0010;
        step(5'b00100, "R9");
        slot_req = 4'b0000;
        step(5'b00100, "R9");
        step(5'b00100, "R9");
    endtask

    task automatic t_idle_turn();
        do_reset();
        slot_fav = 4'b0100;
        step(5'b00001, "R10");
        step(5'b00001, "R10");
        step(5'b00001, "R10");
        slot_req = 4'b0101;
        step(5'b01000, "R10");
        step(5'b00010, "R10");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_hold();
        t_round_robin();
        t_enable();
        t_host_fav();
        t_slot_fav();
        t_fallback();
        t_park_host();
        t_park_prev();
        t_idle_turn();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule